// File: doc/BRIEF.md
# Dual GCRA Cell Policer

This block polices the user cells of many virtual connections against their traffic contracts. Each connection keeps two rate checkers. Both use the virtual-scheduling form of the generic cell rate algorithm and hold their own theoretical arrival time (TAT). One cell is offered at a time with its connection number, a 32-bit arrival timestamp, its cell loss priority (CLP) bit and an AAL5 end-of-frame flag. A verdict follows: pass the cell, tag it (force CLP to 1), or discard it.

Each connection has a context entry, loaded through a configuration write port. The entry holds an enable, a monitor switch, a frame-discard switch, an independence switch, and for each checker its increment, its limit, which CLP class it polices and what it does with offending cells. A connection that is being reconfigured starts again with no history.

Internally a three-state sequence handles each cell. In `ST_IDLE` the block waits, accepts a cell, or takes a configuration write. In `ST_FETCH` it reads the connection context. In `ST_JUDGE` it evaluates both checkers, writes the updated context back and registers the verdict. Transitions: IDLE to FETCH on accept; FETCH to JUDGE always; JUDGE to IDLE always. A configuration write keeps the block in IDLE.

Top module: `upc_dual_gcra`

## Requirements
- R1: After reset every connection is disabled, `out_valid` is 0 and `in_ready` is 1.
- R2: A cell is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `out_valid` then rises two edges later and stays high for exactly one cycle. `in_ready` is 0 during the two cycles in between.
- R3: On a disabled connection every cell gets verdict PASS and `out_clp` equals `in_clp`. Its context is left unchanged.
- R4: A checker with TAT, limit L and increment I finds a cell nonconforming when the 32-bit difference `t - (TAT - L)` is negative as a signed number. The first cell a checker polices after its connection is configured is always conforming. A conforming cell moves TAT to `t` if `t - TAT` is positive as a signed number, otherwise keeps TAT, and then adds I. A nonconforming cell leaves TAT unchanged.
- R5: The 2-bit selector chooses which cells a checker polices: 0 none, 1 only CLP=0 cells, 2 only CLP=1 cells, 3 all cells. A cell that is not selected is neither judged by that checker nor changes its TAT.
- R6: Verdict codes are PASS=0, TAG=1 and DROP=2. For every TAG verdict `out_clp` is 1; otherwise `out_clp` equals the cell's CLP. The 2-bit action codes are as follows. Code 0 drops nonconforming cells. Code 1 tags nonconforming cells. Code 2 tags a nonconforming cell whose CLP is 0 and drops one whose CLP is 1. Code 3 tags every selected cell, and its TAT is not used or changed.
- R7: A drop request from either checker beats any tag. The second checker judges the CLP value left after any tagging by the first, unless the connection's independence bit is set. In that case both checkers see the arriving CLP.
- R8: A checker's TAT is updated only when the cell is forwarded (PASS or TAG). A discarded cell updates neither checker.
- R9: In monitor mode no cell is ever discarded. A cell that would have been dropped gets TAG if either checker asked for a tag, otherwise PASS. It updates TAT as a forwarded cell and does not start frame discard.
- R10: With frame discard on, a policing drop of a cell without the end-of-frame flag starts frame discard. Every later cell on that connection without the flag then gets DROP and updates no TAT. The next cell with the flag is policed normally, and that cell ends the frame discard.
- R11: While `cfg_wr` is 1, `in_ready` is 0. A write is taken on the clock edge while the block is idle. It replaces the connection's settings, clears its frame-discard state and marks both checkers as having seen no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_conn | input | CONN_W | Connection being configured |
| cfg_en | input | 1 | Policing enable |
| cfg_mon | input | 1 | Monitor mode (no discards) |
| cfg_ppd | input | 1 | Frame discard after a policing drop |
| cfg_indep | input | 1 | Both checkers see the arriving CLP |
| cfg_incr | input | 2*32 | Increment per checker, checker k at bits k*32 |
| cfg_lim | input | 2*32 | Limit per checker, checker k at bits k*32 |
| cfg_sel | input | 2*2 | Cell selector per checker, checker k at bits k*2 |
| cfg_act | input | 2*2 | Action code per checker, checker k at bits k*2 |
| in_valid | input | 1 | Cell offered |
| in_ready | output | 1 | Block can accept a cell |
| in_conn | input | CONN_W | Connection of the offered cell |
| in_time | input | 32 | Arrival timestamp (wrapping) |
| in_clp | input | 1 | Cell loss priority of the cell |
| in_eof | input | 1 | AAL5 end-of-frame flag |
| out_valid | output | 1 | Verdict valid pulse |
| out_verdict | output | 2 | PASS=0, TAG=1, DROP=2 |
| out_clp | output | 1 | CLP of the cell after policing |

## Verification
The bench targets the exact boundary of the conformance test, where the difference to `TAT - L` is -1 or 0. A design with an off-by-one comparison would pass a cell that should be dropped, or drop one that should pass. It crosses the 32-bit wrap of the timestamp, where an unsigned compare would drop every cell. It checks that a dropped cell leaves TAT alone, that chained checkers see a tagged CLP unless independent, and that drop beats tag. It also checks frame discard up to and including the end-of-frame cell: getting this wrong would either drop the end-of-frame cell or let the frame's tail pass. Monitor mode must never produce DROP.

// File: rtl/upc_pkg.sv
package upc_pkg;

    localparam int TIME_W = 32;
    localparam int GCRA_N = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CLP0 = 2'd1,
        SEL_CLP1 = 2'd2,
        SEL_ALL  = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ACT_DROP   = 2'd0,
        ACT_TAG    = 2'd1,
        ACT_SPLIT  = 2'd2,
        ACT_TAGALL = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        VERD_PASS = 2'd0,
        VERD_TAG  = 2'd1,
        VERD_DROP = 2'd2
    } verd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_JUDGE = 2'd2
    } pol_state_e;

    typedef struct packed {
        logic [TIME_W-1:0] incr;
        logic [TIME_W-1:0] lim;
        sel_e              sel;
        act_e              act;
    } inst_cfg_t;

    typedef struct packed {
        logic                         en;
        logic                         mon;
        logic                         ppd;
        logic                         indep;
        inst_cfg_t [GCRA_N-1:0]       inst;
    } conn_cfg_t;

endpackage

// File: rtl/upc_gcra_unit.sv
module upc_gcra_unit
    import upc_pkg::*;
(
    input  inst_cfg_t         icfg,
    input  logic [TIME_W-1:0] tat,
    input  logic              fresh,
    input  logic [TIME_W-1:0] now,
    input  logic              clp_seen,
    output logic              drop_req,
    output logic              tag_req,
    output logic              upd_ok,
    output logic [TIME_W-1:0] tat_next
);

    logic              hit;
    logic              nonconf;
    logic [TIME_W-1:0] slack;
    logic [TIME_W-1:0] ahead;
    logic              late;
    logic [TIME_W-1:0] base;

    always_comb begin
        unique case (icfg.sel)
            SEL_NONE: hit = 1'b0;
            SEL_CLP0: hit = !clp_seen;
            SEL_CLP1: hit = clp_seen;
            SEL_ALL:  hit = 1'b1;
            default:  hit = 1'b0;
        endcase
    end

    // Wrap-safe: sign bit of the 32-bit difference decides early arrival.
    assign slack   = now - (tat - icfg.lim);
    assign nonconf = hit && (icfg.act != ACT_TAGALL) && !fresh && slack[TIME_W-1];

    assign ahead = now - tat;
    assign late  = !ahead[TIME_W-1] && (ahead != '0);
    assign base  = (fresh || late) ? now : tat;
    assign tat_next = base + icfg.incr;

    always_comb begin
        drop_req = 1'b0;
        tag_req  = 1'b0;
        unique case (icfg.act)
            ACT_DROP:   drop_req = nonconf;
            ACT_TAG:    tag_req  = nonconf;
            ACT_SPLIT: begin
                drop_req = nonconf && clp_seen;
                tag_req  = nonconf && !clp_seen;
            end
            ACT_TAGALL: tag_req  = hit;
            default: begin
                drop_req = 1'b0;
                tag_req  = 1'b0;
            end
        endcase
    end

    assign upd_ok = hit && !nonconf && (icfg.act != ACT_TAGALL);

endmodule

// File: rtl/upc_ctx_store.sv
module upc_ctx_store
    import upc_pkg::*;
#(
    parameter  int NUM_CONN = 16,
    localparam int CONN_W   = $clog2(NUM_CONN)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_we,
    input  logic [CONN_W-1:0]                cfg_idx,
    input  conn_cfg_t                        cfg_in,
    input  logic [CONN_W-1:0]                rd_idx,
    output conn_cfg_t                        rd_cfg,
    output logic [GCRA_N-1:0][TIME_W-1:0]    rd_tat,
    output logic [GCRA_N-1:0]                rd_fresh,
    output logic                             rd_ppd,
    input  logic                             wb_we,
    input  logic [CONN_W-1:0]                wb_idx,
    input  logic [GCRA_N-1:0]                wb_tat_we,
    input  logic [GCRA_N-1:0][TIME_W-1:0]    wb_tat,
    input  logic                             wb_ppd
);

    conn_cfg_t                     cfg_mem   [NUM_CONN];
    logic [GCRA_N-1:0][TIME_W-1:0] tat_mem   [NUM_CONN];
    logic [GCRA_N-1:0]             fresh_mem [NUM_CONN];
    logic                          ppd_mem   [NUM_CONN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CONN; i++) begin
                cfg_mem[i]   <= '0;
                tat_mem[i]   <= '0;
                fresh_mem[i] <= '1;
                ppd_mem[i]   <= 1'b0;
            end
        end else if (cfg_we) begin
            cfg_mem[cfg_idx]   <= cfg_in;
            fresh_mem[cfg_idx] <= '1;
            ppd_mem[cfg_idx]   <= 1'b0;
        end else if (wb_we) begin
            for (int k = 0; k < GCRA_N; k++) begin
                if (wb_tat_we[k]) begin
                    tat_mem[wb_idx][k]   <= wb_tat[k];
                    fresh_mem[wb_idx][k] <= 1'b0;
                end
            end
            ppd_mem[wb_idx] <= wb_ppd;
        end
    end

    assign rd_cfg   = cfg_mem[rd_idx];
    assign rd_tat   = tat_mem[rd_idx];
    assign rd_fresh = fresh_mem[rd_idx];
    assign rd_ppd   = ppd_mem[rd_idx];

endmodule

// File: rtl/upc_dual_gcra.sv
module upc_dual_gcra
    import upc_pkg::*;
#(
    parameter  int NUM_CONN = 16,
    localparam int CONN_W   = $clog2(NUM_CONN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr,
    input  logic [CONN_W-1:0]          cfg_conn,
    input  logic                       cfg_en,
    input  logic                       cfg_mon,
    input  logic                       cfg_ppd,
    input  logic                       cfg_indep,
    input  logic [GCRA_N*TIME_W-1:0]   cfg_incr,
    input  logic [GCRA_N*TIME_W-1:0]   cfg_lim,
    input  logic [GCRA_N*2-1:0]        cfg_sel,
    input  logic [GCRA_N*2-1:0]        cfg_act,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [CONN_W-1:0]          in_conn,
    input  logic [TIME_W-1:0]          in_time,
    input  logic                       in_clp,
    input  logic                       in_eof,
    output logic                       out_valid,
    output logic [1:0]                 out_verdict,
    output logic                       out_clp
);

    pol_state_e state_q, state_nx;

    logic [CONN_W-1:0]             cell_conn;
    logic [TIME_W-1:0]             cell_time;
    logic                          cell_clp;
    logic                          cell_eof;

    conn_cfg_t                     cur_cfg;
    logic [GCRA_N-1:0][TIME_W-1:0] cur_tat;
    logic [GCRA_N-1:0]             cur_fresh;
    logic                          cur_ppd;

    conn_cfg_t                     rd_cfg;
    logic [GCRA_N-1:0][TIME_W-1:0] rd_tat;
    logic [GCRA_N-1:0]             rd_fresh;
    logic                          rd_ppd;

    conn_cfg_t                     cfg_word;
    logic                          accept;
    logic                          cfg_take;

    logic [GCRA_N-1:0]             drop_v;
    logic [GCRA_N-1:0]             tag_v;
    logic [GCRA_N-1:0]             upd_v;
    logic [GCRA_N-1:0][TIME_W-1:0] tat_nx;
    logic                          clp_chain [GCRA_N];

    logic                          ppd_block;
    logic                          pol_drop;
    logic                          fwd;
    logic                          ppd_nx;
    logic [GCRA_N-1:0]             tat_we;
    verd_e                         verd_nx;
    logic                          clp_nx;
    logic                          wb_we;

    // ---------------- handshake ----------------
    assign in_ready = (state_q == ST_IDLE) && !cfg_wr;
    assign accept   = in_valid && in_ready;
    assign cfg_take = cfg_wr && (state_q == ST_IDLE);

    always_comb begin
        cfg_word       = '0;
        cfg_word.en    = cfg_en;
        cfg_word.mon   = cfg_mon;
        cfg_word.ppd   = cfg_ppd;
        cfg_word.indep = cfg_indep;
        for (int k = 0; k < GCRA_N; k++) begin
            cfg_word.inst[k].incr = cfg_incr[k*TIME_W +: TIME_W];
            cfg_word.inst[k].lim  = cfg_lim[k*TIME_W +: TIME_W];
            cfg_word.inst[k].sel  = sel_e'(cfg_sel[k*2 +: 2]);
            cfg_word.inst[k].act  = act_e'(cfg_act[k*2 +: 2]);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_JUDGE;
            ST_JUDGE: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- cell and context capture ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_conn <= '0;
            cell_time <= '0;
            cell_clp  <= 1'b0;
            cell_eof  <= 1'b0;
            cur_cfg   <= '0;
            cur_tat   <= '0;
            cur_fresh <= '1;
            cur_ppd   <= 1'b0;
        end else begin
            if (accept) begin
                cell_conn <= in_conn;
                cell_time <= in_time;
                cell_clp  <= in_clp;
                cell_eof  <= in_eof;
            end
            if (state_q == ST_FETCH) begin
                cur_cfg   <= rd_cfg;
                cur_tat   <= rd_tat;
                cur_fresh <= rd_fresh;
                cur_ppd   <= rd_ppd;
            end
        end
    end

    upc_ctx_store #(.NUM_CONN(NUM_CONN)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_take),
        .cfg_idx   (cfg_conn),
        .cfg_in    (cfg_word),
        .rd_idx    (cell_conn),
        .rd_cfg    (rd_cfg),
        .rd_tat    (rd_tat),
        .rd_fresh  (rd_fresh),
        .rd_ppd    (rd_ppd),
        .wb_we     (wb_we),
        .wb_idx    (cell_conn),
        .wb_tat_we (tat_we),
        .wb_tat    (tat_nx),
        .wb_ppd    (ppd_nx)
    );

    // ---------------- chained checkers ----------------
    assign clp_chain[0] = cell_clp;

    for (genvar k = 0; k < GCRA_N; k++) begin : g_inst
        logic seen;
        assign seen = cur_cfg.indep ? cell_clp : clp_chain[k];

        upc_gcra_unit u_gcra (
            .icfg     (cur_cfg.inst[k]),
            .tat      (cur_tat[k]),
            .fresh    (cur_fresh[k]),
            .now      (cell_time),
            .clp_seen (seen),
            .drop_req (drop_v[k]),
            .tag_req  (tag_v[k]),
            .upd_ok   (upd_v[k]),
            .tat_next (tat_nx[k])
        );

        if (k + 1 < GCRA_N) begin : g_link
            assign clp_chain[k+1] = clp_chain[k] | tag_v[k];
        end
    end

    // ---------------- verdict resolution ----------------
    assign ppd_block = cur_cfg.en && cur_cfg.ppd && cur_ppd && !cell_eof;
    assign pol_drop  = cur_cfg.en && !ppd_block && (|drop_v) && !cur_cfg.mon;
    assign fwd       = cur_cfg.en && !ppd_block && !pol_drop;
    assign tat_we    = fwd ? upd_v : '0;
    assign wb_we     = (state_q == ST_JUDGE);

    always_comb begin
        ppd_nx = cur_ppd;
        if (cur_cfg.en) begin
            if (ppd_block)
                ppd_nx = 1'b1;
            else if (pol_drop && cur_cfg.ppd && !cell_eof)
                ppd_nx = 1'b1;
            else if (cell_eof)
                ppd_nx = 1'b0;
        end
    end

    always_comb begin
        if (ppd_block || pol_drop) begin
            verd_nx = VERD_DROP;
            clp_nx  = cell_clp;
        end else if (fwd && (|tag_v)) begin
            verd_nx = VERD_TAG;
            clp_nx  = 1'b1;
        end else begin
            verd_nx = VERD_PASS;
            clp_nx  = cell_clp;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_verdict <= VERD_PASS;
            out_clp     <= 1'b0;
        end else begin
            out_valid <= (state_q == ST_JUDGE);
            if (state_q == ST_JUDGE) begin
                out_verdict <= verd_nx;
                out_clp     <= clp_nx;
            end
        end
    end

endmodule

// File: rtl/upc_dual_gcra_chk.sv
module upc_dual_gcra_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       cfg_wr,
    input logic       out_valid,
    input logic [1:0] out_verdict,
    input logic       out_clp,
    input logic       cell_en,
    input logic       cell_mon,
    input logic       cell_clp
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ##3 out_valid); // R2

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_VERDICT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_verdict != 2'd3)); // R6

    AST_TAG_FORCES_CLP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_verdict == 2'd1) |-> out_clp); // R6

    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cell_en) |-> (out_verdict == 2'd0 && out_clp == cell_clp)); // R3

    AST_MONITOR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cell_en && cell_mon) |-> (out_verdict != 2'd2)); // R9

    AST_CFG_BLOCKS_CELLS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> !in_ready); // R11

endmodule

bind upc_dual_gcra upc_dual_gcra_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .cfg_wr      (cfg_wr),
    .out_valid   (out_valid),
    .out_verdict (out_verdict),
    .out_clp     (out_clp),
    .cell_en     (cur_cfg.en),
    .cell_mon    (cur_cfg.mon),
    .cell_clp    (cell_clp)
);

// File: tb/upc_dual_gcra_tb_top.sv
`timescale 1ns/1ps
module upc_dual_gcra_tb_top;

    localparam int NC = 16;
    localparam int CW = 4;
    localparam int TW = 32;
    localparam int NI = 2;

    logic            clk;
    logic            rst_n;
    logic            cfg_wr;
    logic [CW-1:0]   cfg_conn;
    logic            cfg_en, cfg_mon, cfg_ppd, cfg_indep;
    logic [NI*TW-1:0] cfg_incr, cfg_lim;
    logic [NI*2-1:0] cfg_sel, cfg_act;
    logic            in_valid, in_ready;
    logic [CW-1:0]   in_conn;
    logic [TW-1:0]   in_time;
    logic            in_clp, in_eof;
    logic            out_valid;
    logic [1:0]      out_verdict;
    logic            out_clp;

    upc_dual_gcra #(.NUM_CONN(NC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_conn(cfg_conn), .cfg_en(cfg_en), .cfg_mon(cfg_mon),
        .cfg_ppd(cfg_ppd), .cfg_indep(cfg_indep), .cfg_incr(cfg_incr), .cfg_lim(cfg_lim),
        .cfg_sel(cfg_sel), .cfg_act(cfg_act),
        .in_valid(in_valid), .in_ready(in_ready), .in_conn(in_conn), .in_time(in_time),
        .in_clp(in_clp), .in_eof(in_eof),
        .out_valid(out_valid), .out_verdict(out_verdict), .out_clp(out_clp)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // reference state
    bit          m_en [NC], m_mon [NC], m_ppden [NC], m_indep [NC], m_ppd [NC];
    logic [31:0] m_inc [NC][NI], m_lim [NC][NI], m_tat [NC][NI];
    logic [1:0]  m_sel [NC][NI], m_act [NC][NI];
    bit          m_fresh [NC][NI];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] now;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_cell(input int c, input logic [31:0] t, input logic clp,
                              input logic eof, output logic [1:0] ev, output logic ec);
        logic seen, s, hit, nc, anyd, anyt, blk;
        logic dr [NI]; logic tg [NI]; logic up [NI]; logic [31:0] nt [NI];
        logic [31:0] slack, ahead;
        ev = 2'd0; ec = clp;
        if (m_en[c]) begin
            seen = clp; anyd = 0; anyt = 0;
            for (int k = 0; k < NI; k++) begin
                s = m_indep[c] ? clp : seen;
                hit = (m_sel[c][k] == 2'd3) || (m_sel[c][k] == 2'd1 && !s) ||
                      (m_sel[c][k] == 2'd2 && s);
                slack = t - (m_tat[c][k] - m_lim[c][k]);
                nc = hit && m_act[c][k] != 2'd3 && !m_fresh[c][k] && ($signed(slack) < 0);
                dr[k] = nc && (m_act[c][k] == 2'd0 || (m_act[c][k] == 2'd2 && s));
                tg[k] = (nc && (m_act[c][k] == 2'd1 || (m_act[c][k] == 2'd2 && !s))) ||
                        (hit && m_act[c][k] == 2'd3);
                up[k] = hit && !nc && m_act[c][k] != 2'd3;
                ahead = t - m_tat[c][k];
                nt[k] = ((m_fresh[c][k] || $signed(ahead) > 0) ? t : m_tat[c][k]) + m_inc[c][k];
                if (tg[k]) seen = 1'b1;
                anyd |= dr[k];
                anyt |= tg[k];
            end
            blk = m_ppden[c] && m_ppd[c] && !eof;
            if (blk) begin
                ev = 2'd2;
            end else if (anyd && !m_mon[c]) begin
                ev = 2'd2;
                if (m_ppden[c] && !eof) m_ppd[c] = 1;
                else if (eof) m_ppd[c] = 0;
            end else begin
                for (int k = 0; k < NI; k++)
                    if (up[k]) begin m_tat[c][k] = nt[k]; m_fresh[c][k] = 0; end
                if (anyt) begin ev = 2'd1; ec = 1'b1; end
                if (eof) m_ppd[c] = 0;
            end
        end
    endtask

    task automatic do_cfg(input int c, input bit en, input bit mon, input bit ppd, input bit ind,
                          input logic [31:0] i0, input logic [31:0] l0, input logic [1:0] s0, input logic [1:0] a0,
                          input logic [31:0] i1, input logic [31:0] l1, input logic [1:0] s1, input logic [1:0] a1,
                          input bit chk_ready);
        @(negedge clk);
        cfg_wr = 1; cfg_conn = CW'(c); cfg_en = en; cfg_mon = mon; cfg_ppd = ppd; cfg_indep = ind;
        cfg_incr = {i1, i0}; cfg_lim = {l1, l0}; cfg_sel = {s1, s0}; cfg_act = {a1, a0};
        #1;
        if (chk_ready) check(in_ready == 1'b0, "R11", "in_ready during cfg_wr", 32'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 0;
        m_en[c] = en; m_mon[c] = mon; m_ppden[c] = ppd; m_indep[c] = ind; m_ppd[c] = 0;
        m_inc[c][0] = i0; m_lim[c][0] = l0; m_sel[c][0] = s0; m_act[c][0] = a0;
        m_inc[c][1] = i1; m_lim[c][1] = l1; m_sel[c][1] = s1; m_act[c][1] = a1;
        m_fresh[c][0] = 1; m_fresh[c][1] = 1;
    endtask

    task automatic send(input int c, input logic [31:0] t, input logic clp, input logic eof,
                        input string req, input bit tchk);
        logic [1:0] ev; logic ec;
        model_cell(c, t, clp, eof, ev, ec);
        @(negedge clk);
        in_valid = 1; in_conn = CW'(c); in_time = t; in_clp = clp; in_eof = eof;
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        if (tchk) check(!out_valid && !in_ready, "R2", "busy after accept",
                        {30'd0, out_valid, in_ready}, 0);
        @(posedge clk);
        if (tchk) begin
            @(negedge clk);
            check(!out_valid && !in_ready, "R2", "busy second cycle", {30'd0, out_valid, in_ready}, 0);
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid && out_verdict == ev && out_clp == ec, req, "valid/clp/verdict",
              {29'd0, out_valid, out_clp, out_verdict}, {29'd0, 1'b1, ec, ev});
        if (tchk) begin
            @(negedge clk);
            check(!out_valid && in_ready, "R2", "single pulse", {30'd0, out_valid, in_ready}, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 0; cfg_wr = 0; cfg_conn = '0; cfg_en = 0; cfg_mon = 0; cfg_ppd = 0; cfg_indep = 0;
        cfg_incr = '0; cfg_lim = '0; cfg_sel = '0; cfg_act = '0;
        in_valid = 0; in_conn = '0; in_time = '0; in_clp = 0; in_eof = 0;
        for (int c = 0; c < NC; c++) begin
            m_en[c] = 0; m_mon[c] = 0; m_ppden[c] = 0; m_indep[c] = 0; m_ppd[c] = 0;
            for (int k = 0; k < NI; k++) begin
                m_inc[c][k] = 0; m_lim[c][k] = 0; m_tat[c][k] = 0;
                m_sel[c][k] = 0; m_act[c][k] = 0; m_fresh[c][k] = 1;
            end
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check(in_ready == 1 && out_valid == 0, "R1", "reset state",
              {30'd0, in_ready, out_valid}, 2);

        // R1/R3: disabled after reset, CLP untouched
        send(0, 32'd5, 1'b1, 1'b0, "R1", 1);
        send(0, 32'd6, 1'b0, 1'b0, "R3", 0);

        // R4/R8: boundary of conformance, dropped cell leaves TAT alone
        do_cfg(1, 1,0,0,0, 32'd10, 32'd2, 2'd3, 2'd0, 0, 0, 2'd0, 2'd0, 1);
        send(1, 32'd100, 1'b0, 1'b0, "R4", 0);
        send(1, 32'd107, 1'b0, 1'b0, "R4", 0);
        send(1, 32'd108, 1'b0, 1'b0, "R8", 0);
        send(1, 32'd115, 1'b0, 1'b0, "R4", 0);

        // R4: timestamp wrap
        do_cfg(2, 1,0,0,0, 32'd10, 32'd0, 2'd3, 2'd0, 0, 0, 2'd0, 2'd0, 0);
        send(2, 32'hFFFF_FFF0, 1'b0, 1'b0, "R4", 0);
        send(2, 32'd2, 1'b0, 1'b0, "R4", 0);
        send(2, 32'd5, 1'b0, 1'b0, "R4", 0);

        // R5: selector on CLP1 only
        do_cfg(3, 1,0,0,0, 32'd100, 32'd0, 2'd2, 2'd0, 0, 0, 2'd0, 2'd0, 0);
        send(3, 32'd0, 1'b0, 1'b0, "R5", 0);
        send(3, 32'd1, 1'b0, 1'b0, "R5", 0);
        send(3, 32'd10, 1'b1, 1'b0, "R5", 0);
        send(3, 32'd20, 1'b1, 1'b0, "R5", 0);
        send(3, 32'd21, 1'b0, 1'b0, "R5", 0);

        // R6: split action and tag-all
        do_cfg(4, 1,0,0,0, 32'd50, 32'd0, 2'd3, 2'd2, 0, 0, 2'd0, 2'd0, 0);
        send(4, 32'd0, 1'b0, 1'b0, "R6", 0);
        send(4, 32'd1, 1'b0, 1'b0, "R6", 0);
        send(4, 32'd2, 1'b1, 1'b0, "R6", 0);
        do_cfg(5, 1,0,0,0, 32'd50, 32'd0, 2'd1, 2'd3, 0, 0, 2'd0, 2'd0, 0);
        send(5, 32'd0, 1'b0, 1'b0, "R6", 0);
        send(5, 32'd1, 1'b1, 1'b0, "R6", 0);

        // R7: chained CLP view, then independent with drop over tag
        do_cfg(6, 1,0,0,0, 32'd50, 32'd0, 2'd3, 2'd1, 32'd50, 32'd0, 2'd1, 2'd0, 0);
        send(6, 32'd0, 1'b0, 1'b0, "R7", 0);
        send(6, 32'd1, 1'b0, 1'b0, "R7", 0);
        do_cfg(6, 1,0,0,1, 32'd50, 32'd0, 2'd3, 2'd1, 32'd50, 32'd0, 2'd1, 2'd0, 0);
        send(6, 32'd0, 1'b0, 1'b0, "R7", 0);
        send(6, 32'd1, 1'b0, 1'b0, "R7", 0);

        // R9: monitor never drops, frame discard not armed
        do_cfg(7, 1,1,1,0, 32'd50, 32'd0, 2'd3, 2'd0, 0, 0, 2'd0, 2'd0, 0);
        send(7, 32'd0, 1'b0, 1'b0, "R9", 0);
        send(7, 32'd1, 1'b0, 1'b0, "R9", 0);
        send(7, 32'd2, 1'b0, 1'b0, "R9", 0);

        // R10: frame discard through the end-of-frame cell
        do_cfg(8, 1,0,1,0, 32'd50, 32'd0, 2'd3, 2'd0, 0, 0, 2'd0, 2'd0, 0);
        send(8, 32'd0, 1'b0, 1'b0, "R10", 0);
        send(8, 32'd10, 1'b0, 1'b0, "R10", 0);
        send(8, 32'd100, 1'b0, 1'b0, "R10", 0);
        send(8, 32'd101, 1'b0, 1'b1, "R10", 0);
        send(8, 32'd102, 1'b0, 1'b0, "R10", 0);
        send(8, 32'd200, 1'b0, 1'b1, "R10", 0);
        send(8, 32'd300, 1'b0, 1'b0, "R10", 0);

        // random phase across the timestamp wrap
        now = 32'hFFFF_FF80;
        for (int c = 0; c < NC; c++)
            do_cfg(c, ($urandom_range(0, 9) < 8), ($urandom_range(0, 5) == 0), $urandom_range(0, 1), $urandom_range(0, 1),
                   $urandom_range(1, 30), $urandom_range(0, 20), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                   $urandom_range(1, 30), $urandom_range(0, 20), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 0);
        for (int n = 0; n < 500; n++) begin
            if ($urandom_range(0, 24) == 0) begin
                do_cfg($urandom_range(0, NC-1), ($urandom_range(0, 9) < 8), ($urandom_range(0, 5) == 0),
                       $urandom_range(0, 1), $urandom_range(0, 1),
                       $urandom_range(1, 30), $urandom_range(0, 20), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                       $urandom_range(1, 30), $urandom_range(0, 20), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 0);
            end else begin
                now = now + $urandom_range(0, 12);
                send($urandom_range(0, NC-1), now, $urandom_range(0, 1), ($urandom_range(0, 3) == 0),
                     "R4/R7 random", 0);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule